// File: doc/BRIEF.md
# Scatter-Gather Disk Channel DMA Engine

This block moves 16-bit data words between one disk drive port and system memory without processor involvement per word. Software builds a table of 8-byte descriptors in memory, each naming a physical region and its byte length, points the engine at the table, picks a direction and sets the start bit. The engine then fetches descriptors over its memory master port, transfers one memory word per drive request/acknowledge handshake and advances through the table until it reaches the descriptor whose last-entry flag is set.

Completion and failures are reported in a three-bit status code: only "interrupt set, error clear, active clear" means the whole table was moved. A memory error response, or a drive that keeps requesting data after the table is finished, raises the error bit instead. Software may halt a transfer at any time by clearing the start bit.

Top module: `sgdma_channel`

## Requirements
- R1: After reset the command, status and table pointer registers all read 0, `mem_req` is low and `dev_ack` is low.
- R2: Register offsets on `reg_addr`: 0 command (bit 0 start, bit 3 direction), 2 status, 4 table pointer; the pointer stores bits 31:2 of the written value and reads bits 1:0 as 0.
- R3: Descriptors sit at consecutive 8-byte slots from the table pointer: word at +0 is the region base, word at +4 holds the byte count in bits 15:0 (bit 0 ignored) and the last-entry flag in bit 31; bits 30:16 have no effect; the table is walked in order.
- R4: Direction bit 1 moves words from `dev_rdata` into memory writes; direction 0 reads memory and presents each word on `dev_wdata`; each word costs exactly one `dev_ack` and occupies bits 15:0 of the 32-bit memory word.
- R5: Within a region the byte address steps by 2 from the base; bits 31:16 stay those of the base and bits 15:0 wrap modulo 65536.
- R6: When the last descriptor's words are all moved, status bits 2:0 become 3'b100 (bit 2 interrupt, bit 1 error, bit 0 active).
- R7: A drive request after the table has ended is never acknowledged and sets the error bit.
- R8: A memory error response on a descriptor fetch or on a data access sets the error bit, clears active and ends all memory requests; the interrupt bit is not set.
- R9: Status bits 1 and 2 clear when written with 1 and are unchanged when written with 0; bit 5 holds whatever value is written to it, so writing 0x26 clears both event bits and sets bit 5.
- R10: Writing 0 to the start bit mid-transfer leaves active 0 and `mem_req` low from the second clock edge after the write onward, and leaves the interrupt bit as it was.
- R11: A count field of 0 in bits 15:0 describes a 65536-byte region.
- R12: A transfer begins, reloading the table pointer, only when the start bit goes from 0 to 1; writing 1 again while it is already 1 does not restart the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request (valid) |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data, word in bits 15:0 |
| mem_ready | input | 1 | Memory accepts and completes the access this cycle |
| mem_err | input | 1 | Memory error response, valid with `mem_ready` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| dev_req | input | 1 | Drive requests one word transfer |
| dev_ack | output | 1 | Engine completes one word with the drive |
| dev_rdata | input | 16 | Word from the drive |
| dev_wdata | output | 16 | Word to the drive, valid with `dev_ack` |

## Verification
On every cycle the assertions check that the upper address half never moves inside a region, that the engine goes idle after completion, after a memory error and after the start bit drops, that a drive-to-memory acknowledge only answers a request, and that starts and event-bit clears behave as the register rules demand. Only the bench's scenarios can show that descriptor fields are decoded correctly, that each word lands at the right address with the right data in both directions, that the status code ends as 3'b100, 3'b010 or 3'b110 in the matching case, and that a zero count really means a 64 KB region.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;
    localparam int AW = 32;              // memory address width
    localparam int MW = 32;              // memory word width (descriptor word)
    localparam int RW = 32;              // register data width

    localparam logic [2:0] OFS_CMD = 3'd0;
    localparam logic [2:0] OFS_STS = 3'd2;
    localparam logic [2:0] OFS_TBL = 3'd4;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam int STS_ACT = 0;
    localparam int STS_ERR = 1;
    localparam int STS_IRQ = 2;
    localparam int STS_CAP = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_FETCH_C,
        ST_WAIT_DEV,
        ST_XFER,
        ST_ACK,
        ST_HALT
    } walk_st_t;
endpackage

// File: rtl/sgdma_regs.sv
`timescale 1ns/1ps
module sgdma_regs
    import sgdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          active,
    input  logic          ev_done,
    input  logic          ev_err,
    output logic          run,
    output logic          go,
    output logic          to_mem,
    output logic [AW-1:0] tbl_base
);
    typedef struct packed {
        logic          start;
        logic          dir;
        logic          go;
        logic          err;
        logic          irq;
        logic          cap;
        logic [AW-1:0] tbl;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_cmd, wr_sts, wr_tbl;

    always_comb begin
        wr_cmd = reg_we && (reg_addr == OFS_CMD);
        wr_sts = reg_we && (reg_addr == OFS_STS);
        wr_tbl = reg_we && (reg_addr == OFS_TBL);

        st_d    = st_q;
        st_d.go = 1'b0;
        if (wr_cmd) begin
            st_d.start = reg_wdata[CMD_GO];
            st_d.dir   = reg_wdata[CMD_DIR];
            st_d.go    = reg_wdata[CMD_GO] && !st_q.start;
        end
        if (wr_sts) begin
            if (reg_wdata[STS_ERR]) st_d.err = 1'b0;
            if (reg_wdata[STS_IRQ]) st_d.irq = 1'b0;
            st_d.cap = reg_wdata[STS_CAP];
        end
        if (wr_tbl) st_d.tbl = {reg_wdata[AW-1:2], 2'b00};
        // hardware events win over a same-cycle software clear
        if (ev_err)  st_d.err = 1'b1;
        if (ev_done) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_CMD: reg_rdata = {{(RW-4){1'b0}}, st_q.dir, 2'b00, st_q.start};
            OFS_STS: reg_rdata = {{(RW-6){1'b0}}, st_q.cap, 2'b00, st_q.irq, st_q.err, active};
            OFS_TBL: reg_rdata = st_q.tbl;
            default: reg_rdata = '0;
        endcase
    end

    assign run      = st_q.start;
    assign go       = st_q.go;
    assign to_mem   = st_q.dir;
    assign tbl_base = st_q.tbl;

    // R9: a write of 1 to the error bit clears it unless an error event coincides
    a_r9_err_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && reg_wdata[STS_ERR] && !ev_err) |=> !st_q.err);

    // R12: a start pulse only follows a 0-to-1 change of the start bit
    a_r12_go_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.go |-> (st_q.start && !$past(st_q.start)));
endmodule

// File: rtl/sgdma_walker.sv
`timescale 1ns/1ps
module sgdma_walker
    import sgdma_pkg::*;
#(
    parameter int DW    = 16,   // drive data word width
    parameter int CNT_W = 16    // byte count field width, also region page width
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          go,
    input  logic          to_mem,
    input  logic [AW-1:0] tbl_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [MW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_err,
    input  logic [MW-1:0] mem_rdata,
    input  logic          dev_req,
    output logic          dev_ack,
    input  logic [DW-1:0] dev_rdata,
    output logic [DW-1:0] dev_wdata,
    output logic          active,
    output logic          ev_done,
    output logic          ev_err
);
    localparam int                SH         = $clog2(DW / 8);
    localparam logic [CNT_W-1:0]  FULL_WORDS = CNT_W'(1) << (CNT_W - SH);
    localparam logic [CNT_W-1:0]  ONE_WORD   = CNT_W'(1);
    localparam logic [CNT_W-1:0]  ADDR_STEP  = CNT_W'(DW / 8);
    localparam logic [AW-1:0]     DESC_STEP  = AW'(MW / 8);

    typedef struct packed {
        walk_st_t         st;
        logic [AW-1:0]    ptr;
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] left;
        logic             last;
        logic [DW-1:0]    data;
    } walk_t;

    walk_t            wk_d, wk_q;
    logic             rsp_ok, rsp_bad;
    logic [CNT_W-1:0] cnt_field, words;
    logic [AW-1:0]    addr_next;

    always_comb begin
        rsp_ok    = mem_ready && !mem_err;
        rsp_bad   = mem_ready && mem_err;
        cnt_field = mem_rdata[CNT_W-1:0];
        words     = (cnt_field == '0) ? FULL_WORDS : (cnt_field >> SH);
        // only the low page bits advance; a region never leaves its 64 KB page
        addr_next = {wk_q.addr[AW-1:CNT_W], wk_q.addr[CNT_W-1:0] + ADDR_STEP};

        wk_d      = wk_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = wk_q.addr;
        mem_wdata = {{(MW-DW){1'b0}}, wk_q.data};
        dev_ack   = 1'b0;
        dev_wdata = wk_q.data;
        ev_done   = 1'b0;
        ev_err    = 1'b0;

        if (!run) begin
            wk_d.st = ST_IDLE;
        end else begin
            case (wk_q.st)
                ST_IDLE: begin
                    if (go) begin
                        wk_d.st  = ST_FETCH_A;
                        wk_d.ptr = tbl_base;
                    end
                end
                ST_FETCH_A: begin
                    mem_req  = 1'b1;
                    mem_addr = wk_q.ptr;
                    if (rsp_bad) begin
                        ev_err  = 1'b1;
                        wk_d.st = ST_HALT;
                    end else if (rsp_ok) begin
                        wk_d.addr = mem_rdata[AW-1:0];
                        wk_d.ptr  = wk_q.ptr + DESC_STEP;
                        wk_d.st   = ST_FETCH_C;
                    end
                end
                ST_FETCH_C: begin
                    mem_req  = 1'b1;
                    mem_addr = wk_q.ptr;
                    if (rsp_bad) begin
                        ev_err  = 1'b1;
                        wk_d.st = ST_HALT;
                    end else if (rsp_ok) begin
                        wk_d.left = words;
                        wk_d.last = mem_rdata[MW-1];
                        wk_d.ptr  = wk_q.ptr + DESC_STEP;
                        wk_d.st   = ST_WAIT_DEV;
                    end
                end
                ST_WAIT_DEV: begin
                    if (wk_q.left == '0) begin
                        if (wk_q.last) begin
                            ev_done = 1'b1;
                            wk_d.st = ST_HALT;
                        end else begin
                            wk_d.st = ST_FETCH_A;
                        end
                    end else if (dev_req) begin
                        if (to_mem) begin
                            dev_ack   = 1'b1;
                            wk_d.data = dev_rdata;
                        end
                        wk_d.st = ST_XFER;
                    end
                end
                ST_XFER: begin
                    mem_req = 1'b1;
                    mem_we  = to_mem;
                    if (rsp_bad) begin
                        ev_err  = 1'b1;
                        wk_d.st = ST_HALT;
                    end else if (rsp_ok) begin
                        if (to_mem) begin
                            wk_d.addr = addr_next;
                            wk_d.left = wk_q.left - ONE_WORD;
                            wk_d.st   = ST_WAIT_DEV;
                        end else begin
                            wk_d.data = mem_rdata[DW-1:0];
                            wk_d.st   = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    dev_ack   = 1'b1;
                    wk_d.addr = addr_next;
                    wk_d.left = wk_q.left - ONE_WORD;
                    wk_d.st   = ST_WAIT_DEV;
                end
                ST_HALT: begin
                    // table finished or failed: any further drive request is an overrun
                    if (dev_req) ev_err = 1'b1;
                end
                default: wk_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wk_q <= '{st: ST_IDLE, default: '0};
        else        wk_q <= wk_d;
    end

    assign active = (wk_q.st != ST_IDLE) && (wk_q.st != ST_HALT);

    // R5: the upper address half only changes when a new base is loaded
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_q.st != ST_FETCH_A) |=> (wk_q.addr[AW-1:CNT_W] == $past(wk_q.addr[AW-1:CNT_W])));

    // R6: completion leaves the engine inactive
    a_r6_done_idles: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> !active);

    // R8: an error response stops all memory traffic
    a_r8_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err) |=> (!active && !mem_req));

    // R10: with the start bit clear the engine is idle by the next edge
    a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!active && !mem_req));

    // R4: a drive-to-memory acknowledge always answers a request
    a_r4_ack_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack && to_mem) |-> dev_req);
endmodule

// File: rtl/sgdma_channel.sv
`timescale 1ns/1ps
module sgdma_channel
    import sgdma_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 16
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    input  logic          dev_req,
    output logic          dev_ack,
    input  logic [DW-1:0] dev_rdata,
    output logic [DW-1:0] dev_wdata
);
    logic          run, go, to_mem, active, ev_done, ev_err;
    logic [AW-1:0] tbl_base;

    sgdma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .active    (active),
        .ev_done   (ev_done),
        .ev_err    (ev_err),
        .run       (run),
        .go        (go),
        .to_mem    (to_mem),
        .tbl_base  (tbl_base)
    );

    sgdma_walker #(.DW(DW), .CNT_W(CNT_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .go        (go),
        .to_mem    (to_mem),
        .tbl_base  (tbl_base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .dev_req   (dev_req),
        .dev_ack   (dev_ack),
        .dev_rdata (dev_rdata),
        .dev_wdata (dev_wdata),
        .active    (active),
        .ev_done   (ev_done),
        .ev_err    (ev_err)
    );
endmodule

// File: tb/sim_sgdma_channel.sv
`timescale 1ns/1ps
module sim_sgdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        dev_req = 1'b0;
    logic        dev_ack;
    logic [15:0] dev_rdata = '0;
    logic [15:0] dev_wdata;

    always #2 clk = ~clk;   // 250 MHz

    sgdma_channel u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] tbl_mem [0:63];
    logic [15:0] wrmem [logic [31:0]];
    int          wr_cnt = 0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    logic [31:0] db [0:7];
    logic [31:0] dc [0:7];
    int          nd;
    logic [31:0] eq [$];
    logic [15:0] sent [$];

    function automatic logic [15:0] pat(logic [31:0] a);
        return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h3C5A;
    endfunction

    function automatic int nwords(logic [31:0] c);
        if (c[15:0] == 16'h0) return 32768;
        return int'(c[15:1]);
    endfunction

    // memory model: table window 0x100..0x1FF, everything else is patterned data
    always @(negedge clk) begin
        if (mem_req && err_en && mem_addr == err_addr) begin
            mem_ready = 1'b1;
            mem_err   = 1'b1;
        end else begin
            mem_ready = mem_req && ($urandom_range(0, 3) != 0);
            mem_err   = 1'b0;
        end
        if (mem_addr[31:8] == 24'h000001) mem_rdata = tbl_mem[mem_addr[7:2]];
        else                              mem_rdata = {16'h0, pat(mem_addr)};
    end

    always @(posedge clk) begin
        if (mem_req && mem_ready && !mem_err && mem_we) begin
            wrmem[mem_addr] = mem_wdata[15:0];
            wr_cnt++;
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            report();
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic sts_chk(string tag, logic [2:0] exp);
        logic [31:0] v;
        reg_rd(3'd2, v);
        chk(tag, {29'h0, v[2:0]}, {29'h0, exp});
    endtask

    task automatic xfer_word(logic [15:0] wv, int tmo, output bit got, output logic [15:0] rv);
        @(negedge clk);
        dev_req = 1'b1; dev_rdata = wv; got = 1'b0; rv = '0;
        for (int t = 0; t < tmo && !got; t++) begin
            #1;
            if (dev_ack) begin got = 1'b1; rv = dev_wdata; end
            else @(negedge clk);
        end
        if (got) @(negedge clk);
        dev_req = 1'b0;
    endtask

    task automatic load_tbl();
        eq.delete();
        for (int i = 0; i < nd; i++) begin
            tbl_mem[2*i]   = db[i];
            tbl_mem[2*i+1] = dc[i] | ((i == nd - 1) ? 32'h8000_0000 : 32'h0);
            for (int k = 0; k < nwords(dc[i]); k++)
                eq.push_back({db[i][31:16], db[i][15:0] + 16'(2*k)});
        end
    endtask

    task automatic start_xfer(bit to_mem, bit clear);
        load_tbl();
        sent.delete();
        wrmem.delete();
        wr_cnt = 0;
        reg_wr(3'd4, 32'h100);
        reg_wr(3'd0, 32'h0);
        if (clear) reg_wr(3'd2, 32'h26);
        reg_wr(3'd0, {28'h0, to_mem, 3'b001});
    endtask

    task automatic move_words(bit to_mem, int first, int n, string tag);
        bit got;
        logic [15:0] rv, w;
        for (int k = first; k < first + n; k++) begin
            w = 16'($urandom);
            sent.push_back(w);
            xfer_word(w, 200, got, rv);
            chk({tag, " ack"}, {31'h0, got}, 32'h1);
            if (!to_mem) chk({tag, " R4 word to drive"}, {16'h0, rv}, {16'h0, pat(eq[k])});
        end
    endtask

    task automatic mem_check(string tag);
        for (int k = 0; k < eq.size(); k++)
            chk({tag, " R4 R5 memory word"},
                {16'h0, wrmem.exists(eq[k]) ? wrmem[eq[k]] : 16'hDEAD}, {16'h0, sent[k]});
        chk({tag, " R4 write count"}, 32'(wr_cnt), 32'(eq.size()));
    endtask

    task automatic full_run(bit to_mem, string tag);
        start_xfer(to_mem, 1'b1);
        move_words(to_mem, 0, eq.size(), tag);
        repeat (12) @(negedge clk);
        if (to_mem) mem_check(tag);
        sts_chk({tag, " R6 done status"}, 3'b100);
    endtask

    initial begin
        logic [31:0] v;
        bit got;
        logic [15:0] rv;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) tbl_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(3'd0, v); chk("R1 command reset", v, 32'h0);
        reg_rd(3'd2, v); chk("R1 status reset", v, 32'h0);
        reg_rd(3'd4, v); chk("R1 pointer reset", v, 32'h0);
        chk("R1 mem_req reset", {31'h0, mem_req}, 32'h0);
        chk("R1 dev_ack reset", {31'h0, dev_ack}, 32'h0);

        // R2 register layout
        reg_wr(3'd4, 32'h1234_567B);
        reg_rd(3'd4, v); chk("R2 pointer low bits", v, 32'h1234_5678);
        reg_wr(3'd0, 32'h0000_0008);
        reg_rd(3'd0, v); chk("R2 direction bit", v, 32'h8);
        reg_rd(3'd2, v); chk("R2 no start no activity", v, 32'h0);
        reg_wr(3'd0, 32'h0);

        // R9 capability flag and clear write
        reg_wr(3'd2, 32'h20);
        reg_rd(3'd2, v); chk("R9 flag bit5 set", v, 32'h20);
        reg_wr(3'd2, 32'h26);
        reg_rd(3'd2, v); chk("R9 0x26 write", v, 32'h20);

        // R3 R4 R5 directed memory-to-drive with ignored count bits and a page wrap
        nd = 3;
        db[0] = 32'h0000_2000; dc[0] = 32'h1234_0006;
        db[1] = 32'h0002_FFFC; dc[1] = 32'h0000_0008;
        db[2] = 32'h0000_3010; dc[2] = 32'h0000_0002;
        full_run(1'b0, "R3 to-drive");
        chk("R3 word total", 32'(eq.size()), 32'd8);

        // R7 overrun after the table ended
        dev_req = 1'b1;
        got = 1'b0;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            if (dev_ack) got = 1'b1;
        end
        chk("R7 no ack after end", {31'h0, got}, 32'h0);
        dev_req = 1'b0;
        sts_chk("R7 overrun status", 3'b110);

        // R9 partial clear: error only
        reg_wr(3'd2, 32'h22);
        sts_chk("R9 clear error keeps irq", 3'b100);
        reg_wr(3'd2, 32'h24);
        sts_chk("R9 clear irq", 3'b000);

        // R4 R5 directed drive-to-memory with page wrap
        nd = 2;
        db[0] = 32'h0005_FFFE; dc[0] = 32'h0000_0004;
        db[1] = 32'h0000_4000; dc[1] = 32'h7FFF_000A;
        full_run(1'b1, "R5 to-mem");

        // random transfers
        for (int it = 0; it < 6; it++) begin
            bit d;
            nd = 1 + int'($urandom_range(0, 2));
            for (int i = 0; i < nd; i++) begin
                db[i] = {16'(1 + it*4 + i), 15'($urandom), 1'b0};
                dc[i] = ($urandom & 32'h7FFF_0000) | 32'(2 * (1 + $urandom_range(0, 11)));
            end
            d = 1'($urandom);
            full_run(d, d ? "R4 random to-mem" : "R4 random to-drive");
        end

        // R8 error on a descriptor fetch
        nd = 2;
        db[0] = 32'h0000_6000; dc[0] = 32'h4;
        db[1] = 32'h0000_7000; dc[1] = 32'h4;
        err_en = 1'b1; err_addr = 32'h0000_010C;
        start_xfer(1'b0, 1'b1);
        move_words(1'b0, 0, 2, "R8 fetch");
        repeat (8) @(negedge clk);
        sts_chk("R8 fetch error status", 3'b010);
        chk("R8 no request after error", {31'h0, mem_req}, 32'h0);

        // R8 error on a data write
        nd = 1;
        db[0] = 32'h0000_8000; dc[0] = 32'h8;
        err_addr = 32'h0000_8002;
        start_xfer(1'b1, 1'b1);
        move_words(1'b1, 0, 2, "R8 data");
        repeat (8) @(negedge clk);
        err_en = 1'b0;
        sts_chk("R8 data error status", 3'b010);
        chk("R8 writes before error", 32'(wr_cnt), 32'd1);

        // a short success so the interrupt bit is set
        nd = 1;
        db[0] = 32'h0000_9000; dc[0] = 32'h2;
        full_run(1'b0, "R6 short");

        // R11 zero count, R12 no restart, R10 stop keeps irq
        nd = 1;
        db[0] = 32'h000A_0000; dc[0] = 32'h0;
        start_xfer(1'b0, 1'b0);
        chk("R11 zero count length", 32'(eq.size()), 32'd32768);
        move_words(1'b0, 0, 40, "R11 zero count");
        sts_chk("R11 still active after 40 words", 3'b101);
        reg_wr(3'd0, 32'h1);
        move_words(1'b0, 40, 5, "R12 no restart");
        @(negedge clk);
        dev_req = 1'b1;
        reg_wr(3'd0, 32'h0);
        @(negedge clk);
        chk("R10 mem_req after stop", {31'h0, mem_req}, 32'h0);
        dev_req = 1'b0;
        sts_chk("R10 stop keeps irq", 3'b100);
        reg_rd(3'd2, v); chk("R9 flag held", {31'h0, v[5]}, 32'h1);

        report();
    end
endmodule